// File: doc/BRIEF.md
# Clock Multiplier Control Interlock

This block holds the software-visible controls of a system clock source that can either be divided down or multiplied up. One register write carries a multiplier-enable bit, a 4X/2X select bit, a two-bit divide field and a clock-ready bit. The block accepts or ignores each field according to fixed ordering rules, and it times the multiplier's settling period with a counter. It reports the result as a ready flag and as a registered clock-select code for a downstream clock mux.

The ordering rules keep the clock tree out of illegal states. The multiplier can only be switched on or off while the divide field selects divide-by-1 and the external ring-mode input is low. The 4X/2X choice is frozen while the multiplier is on. The multiplied setting in the divide field is accepted only once the startup count has finished. Every acceptance test uses the register values held before the write.

Top module: `clkmul_ctrl`

## Requirements
- R1: A synchronous reset leaves enable 0, select 0 (2X), divide field 10b, ready 0 and clock-select 000b.
- R2: A write updates the 4X/2X select bit (1 = 4X) only if enable was 0 before the write. Otherwise the bit keeps its value.
- R3: A write updates the enable bit only if the divide field held 10b (divide-by-1) and ring_mode_i was 0. Otherwise the bit keeps its value.
- R4: When enable goes 0 to 1, ready is 0 in the following cycle. Ready becomes 1 exactly STARTUP_CYCLES clock cycles after the accepting write edge and stays 1 while enable stays 1.
- R5: A write of 00b (multiplied) to the divide field is rejected, leaving the field unchanged, unless enable and ready were both 1. It is also rejected if the same write clears enable.
- R6: A write of 01b (divide-by-4), 10b (divide-by-1) or 11b (divide-by-1024) to the divide field is always accepted.
- R7: Clearing enable sets ready to 0 on the next cycle and abandons any count in progress. Enabling again restarts the full STARTUP_CYCLES count.
- R8: The ready bit in the write data has no effect on the ready flag.
- R9: clk_sel_o is registered and reflects the fields one cycle after they change: divide-by-1 gives 000b, divide-by-4 gives 001b, divide-by-1024 gives 010b, the multiplied setting with 2X gives 110b, and with 4X gives 111b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_i | input | 1 | Register write strobe |
| wr_mul_en_i | input | 1 | Write data: multiplier enable |
| wr_mul_4x_i | input | 1 | Write data: 1 = 4X, 0 = 2X |
| wr_div_i | input | 2 | Write data: divide field |
| wr_ready_i | input | 1 | Write data: ready bit (ignored) |
| ring_mode_i | input | 1 | Ring-mode state; blocks enable changes when 1 |
| mul_en_o | output | 1 | Multiplier enable register |
| mul_4x_o | output | 1 | 4X/2X select register |
| div_o | output | 2 | Divide field register |
| ready_o | output | 1 | Multiplier ready flag |
| clk_sel_o | output | 3 | Registered clock-select code |

## Verification
The bench builds the block with STARTUP_CYCLES = 5. This brings the end of the settling window within a handful of cycles, so the exact rise cycle of ready and the rejection of the multiplied setting just before it can both be observed directly. With that short window the bench can apply every combination of the write fields and ring_mode_i (64 codes), in three different orders, starting from reset, counting and ready states. A cycle model built from the requirements predicts every register, the ready flag and the clock-select code after each write.

// File: rtl/clkmul_pkg.sv
package clkmul_pkg;
  typedef enum logic [1:0] {
    DIV_MULT  = 2'b00,
    DIV_BY4   = 2'b01,
    DIV_BY1   = 2'b10,
    DIV_BY1K  = 2'b11
  } div_code_e;

  localparam logic [2:0] SEL_DIV1  = 3'b000;
  localparam logic [2:0] SEL_DIV4  = 3'b001;
  localparam logic [2:0] SEL_DIV1K = 3'b010;
  localparam logic [2:0] SEL_MUL2  = 3'b110;
  localparam logic [2:0] SEL_MUL4  = 3'b111;
endpackage

// File: rtl/clkmul_startup.sv
module clkmul_startup #(
  parameter int unsigned STARTUP_CYCLES = 65536
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic abort_i,
  output logic ready_o
);
  localparam int unsigned CW = (STARTUP_CYCLES < 2) ? 1 : $clog2(STARTUP_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(STARTUP_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (rst || abort_i) begin
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      ready_o <= 1'b0;
    end else if (start_i) begin
      cnt_q   <= '0;
      busy_q  <= 1'b1;
      ready_o <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q  <= 1'b0;
        ready_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/clkmul_regs.sv
module clkmul_regs
  import clkmul_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_i,
  input  logic      wr_mul_en_i,
  input  logic      wr_mul_4x_i,
  input  logic [1:0] wr_div_i,
  input  logic      ring_mode_i,
  input  logic      ready_i,
  output logic      mul_en_o,
  output logic      mul_4x_o,
  output div_code_e div_o,
  output logic      start_o,
  output logic      abort_o
);
  logic en_ok, sel_ok, div_ok;

  always_comb begin
    en_ok   = wr_i && (div_o == DIV_BY1) && !ring_mode_i;
    start_o = en_ok && wr_mul_en_i && !mul_en_o;
    abort_o = en_ok && !wr_mul_en_i && mul_en_o;
    sel_ok  = wr_i && !mul_en_o;
    div_ok  = wr_i && ((div_code_e'(wr_div_i) != DIV_MULT) ||
                       (mul_en_o && ready_i && !abort_o));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mul_en_o <= 1'b0;
      mul_4x_o <= 1'b0;
      div_o    <= DIV_BY1;
    end else begin
      if (en_ok)  mul_en_o <= wr_mul_en_i;
      if (sel_ok) mul_4x_o <= wr_mul_4x_i;
      if (div_ok) div_o    <= div_code_e'(wr_div_i);
    end
  end
endmodule

// File: rtl/clkmul_selenc.sv
module clkmul_selenc
  import clkmul_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  div_code_e div_i,
  input  logic      mul_4x_i,
  output logic [2:0] clk_sel_o
);
  logic [2:0] sel_d;

  always_comb begin
    unique case (div_i)
      DIV_MULT: sel_d = mul_4x_i ? SEL_MUL4 : SEL_MUL2;
      DIV_BY4:  sel_d = SEL_DIV4;
      DIV_BY1K: sel_d = SEL_DIV1K;
      default:  sel_d = SEL_DIV1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) clk_sel_o <= SEL_DIV1;
    else     clk_sel_o <= sel_d;
  end
endmodule

// File: rtl/clkmul_ctrl.sv
module clkmul_ctrl
  import clkmul_pkg::*;
#(
  parameter int unsigned STARTUP_CYCLES = 65536
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_i,
  input  logic       wr_mul_en_i,
  input  logic       wr_mul_4x_i,
  input  logic [1:0] wr_div_i,
  input  logic       wr_ready_i,
  input  logic       ring_mode_i,
  output logic       mul_en_o,
  output logic       mul_4x_o,
  output logic [1:0] div_o,
  output logic       ready_o,
  output logic [2:0] clk_sel_o
);
  div_code_e div_q;
  logic      start, abort;
  logic      unused_ready_bit;

  // R8: the ready bit of the write word is not wired to any state
  assign unused_ready_bit = wr_ready_i;

  clkmul_regs u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_i        (wr_i),
    .wr_mul_en_i (wr_mul_en_i),
    .wr_mul_4x_i (wr_mul_4x_i),
    .wr_div_i    (wr_div_i),
    .ring_mode_i (ring_mode_i),
    .ready_i     (ready_o),
    .mul_en_o    (mul_en_o),
    .mul_4x_o    (mul_4x_o),
    .div_o       (div_q),
    .start_o     (start),
    .abort_o     (abort)
  );

  clkmul_startup #(.STARTUP_CYCLES(STARTUP_CYCLES)) u_startup (
    .clk     (clk),
    .rst     (rst),
    .start_i (start),
    .abort_i (abort),
    .ready_o (ready_o)
  );

  clkmul_selenc u_selenc (
    .clk       (clk),
    .rst       (rst),
    .div_i     (div_q),
    .mul_4x_i  (mul_4x_o),
    .clk_sel_o (clk_sel_o)
  );

  assign div_o = div_q;
endmodule

// File: rtl/clkmul_ctrl_chk.sv
module clkmul_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_i,
  input logic       ring_mode_i,
  input logic       mul_en_o,
  input logic       mul_4x_o,
  input logic [1:0] div_o,
  input logic       ready_o
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!mul_en_o && !mul_4x_o && div_o == 2'b10 && !ready_o));

  assert_sel_frozen_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(mul_4x_o) |-> ($past(wr_i) && !$past(mul_en_o)));

  assert_en_gated_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(mul_en_o) |-> ($past(wr_i) && $past(div_o) == 2'b10 && !$past(ring_mode_i)));

  assert_ready_low_on_enable_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(mul_en_o) |-> !ready_o);

  assert_mult_needs_ready_R5: assert property (@(posedge clk) disable iff (rst)
    (div_o == 2'b00) |-> (mul_en_o && ready_o));

  assert_ready_needs_en_R7: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> mul_en_o);
endmodule

bind clkmul_ctrl clkmul_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_i        (wr_i),
  .ring_mode_i (ring_mode_i),
  .mul_en_o    (mul_en_o),
  .mul_4x_o    (mul_4x_o),
  .div_o       (div_o),
  .ready_o     (ready_o)
);

// File: tb/tb_clkmul_ctrl.sv
module tb_clkmul_ctrl;
  localparam int N = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_i = 1'b0, wr_mul_en_i = 1'b0, wr_mul_4x_i = 1'b0, wr_ready_i = 1'b0, ring_mode_i = 1'b0;
  logic [1:0] wr_div_i = 2'b10;
  logic       mul_en_o, mul_4x_o, ready_o;
  logic [1:0] div_o;
  logic [2:0] clk_sel_o;

  int checks = 0, fails = 0;

  // model state
  logic       m_en, m_sel, m_rdy, m_busy;
  logic [1:0] m_div;
  logic [2:0] m_csel;
  int         m_cnt;

  always #5 clk = ~clk;

  clkmul_ctrl #(.STARTUP_CYCLES(N)) dut (
    .clk(clk), .rst(rst), .wr_i(wr_i), .wr_mul_en_i(wr_mul_en_i),
    .wr_mul_4x_i(wr_mul_4x_i), .wr_div_i(wr_div_i), .wr_ready_i(wr_ready_i),
    .ring_mode_i(ring_mode_i), .mul_en_o(mul_en_o), .mul_4x_o(mul_4x_o),
    .div_o(div_o), .ready_o(ready_o), .clk_sel_o(clk_sel_o)
  );

  function automatic logic [2:0] enc(input logic [1:0] d, input logic s);
    case (d)
      2'b00:   enc = s ? 3'b111 : 3'b110;
      2'b01:   enc = 3'b001;
      2'b11:   enc = 3'b010;
      default: enc = 3'b000;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R3 enable", int'(mul_en_o), int'(m_en));
    chk("R2 select", int'(mul_4x_o), int'(m_sel));
    chk("R5/R6 divide", int'(div_o), int'(m_div));
    chk("R4/R7/R8 ready", int'(ready_o), int'(m_rdy));
    chk("R9 clk_sel", int'(clk_sel_o), int'(m_csel));
  endtask

  task automatic step(input logic w, input logic ring, input logic en,
                      input logic sel, input logic [1:0] d, input logic rb);
    logic en_ok, abrt, strt;
    wr_i = w; ring_mode_i = ring; wr_mul_en_i = en; wr_mul_4x_i = sel;
    wr_div_i = d; wr_ready_i = rb;
    @(posedge clk);
    m_csel = enc(m_div, m_sel);
    en_ok = w && (m_div == 2'b10) && !ring;
    abrt  = en_ok && !en && m_en;
    strt  = en_ok && en && !m_en;
    if (w && !m_en) m_sel = sel;
    if (w && (d != 2'b00 || (m_en && m_rdy && !abrt))) m_div = d;
    if (abrt) begin m_rdy = 0; m_busy = 0; end
    else if (strt) begin m_rdy = 0; m_busy = 1; m_cnt = 0; end
    else if (m_busy) begin
      if (m_cnt == N - 1) begin m_busy = 0; m_rdy = 1; end
      else m_cnt++;
    end
    if (en_ok) m_en = en;
    @(negedge clk);
    wr_i = 0;
    cmp_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 2'b10, 0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    m_en = 0; m_sel = 0; m_rdy = 0; m_busy = 0; m_div = 2'b10; m_csel = 3'b000; m_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 enable", int'(mul_en_o), 0);
    chk("R1 select", int'(mul_4x_o), 0);
    chk("R1 divide", int'(div_o), 2);
    chk("R1 ready", int'(ready_o), 0);
    chk("R1 clk_sel", int'(clk_sel_o), 0);

    // R5: multiplied setting rejected with multiplier off
    step(1, 0, 0, 0, 2'b00, 0);
    chk("R5 div00 while off", int'(div_o), 2);
    // R8: ready bit ignored while off
    step(1, 0, 0, 1, 2'b10, 1);
    chk("R8 ready write off", int'(ready_o), 0);
    // R3: ring mode blocks enable
    step(1, 1, 1, 1, 2'b10, 0);
    chk("R3 ring blocks", int'(mul_en_o), 0);

    // R4: enable, count exact rise cycle, R5 reject just before
    step(1, 0, 1, 1, 2'b10, 1);
    chk("R4 ready cleared", int'(ready_o), 0);
    for (int k = 1; k < N; k++) begin
      if (k == N - 1) begin
        step(1, 0, 1, 0, 2'b00, 1);
        chk("R5 div00 during count", int'(div_o), 2);
        chk("R2 select frozen", int'(mul_4x_o), 1);
      end else step(0, 0, 0, 0, 2'b10, 0);
      chk("R4 ready low in window", int'(ready_o), 0);
    end
    step(0, 0, 0, 0, 2'b10, 0);
    chk("R4 ready at N", int'(ready_o), 1);
    step(1, 0, 1, 0, 2'b00, 0);
    chk("R6 div00 accepted", int'(div_o), 0);
    step(0, 0, 0, 0, 2'b00, 0);
    chk("R9 x4 code", int'(clk_sel_o), 7);
    // R3: enable cannot clear while multiplied
    step(1, 0, 0, 0, 2'b00, 0);
    chk("R3 clear blocked", int'(mul_en_o), 1);
    step(1, 0, 1, 0, 2'b11, 0);
    chk("R6 div1024", int'(div_o), 3);
    step(1, 0, 1, 0, 2'b10, 0);
    // R7: clear with 00 in the same write
    step(1, 0, 0, 0, 2'b00, 0);
    chk("R7 ready cleared", int'(ready_o), 0);
    chk("R5 div00 with clear", int'(div_o), 2);
    // R7: abort mid-count then restart full count
    step(1, 0, 1, 0, 2'b10, 0);
    idle(2);
    step(1, 0, 0, 0, 2'b10, 0);
    step(1, 0, 1, 0, 2'b10, 0);
    idle(N - 1);
    chk("R7 restarted count low", int'(ready_o), 0);
    idle(1);
    chk("R7 restarted count high", int'(ready_o), 1);

    // near-exhaustive sweeps of write codes x ring mode
    for (int p = 0; p < 3; p++) begin
      for (int a = 0; a < 64; a++) begin
        logic [5:0] c;
        c = (p == 0) ? 6'(a) : (p == 1) ? 6'(a ^ 6'h2A) : 6'(63 - a);
        step(1, c[5], c[4], c[3], c[2:1], c[0]);
        if (a % 8 == 7) idle(N + 1);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule